// File: doc/BRIEF.md
# Card Command Issue and Response Capture

This block is the command path of a memory-card host controller. Software writes a 16-bit command word. The block decodes it into its fields and hands the command index and a 32-bit argument to an abstract card-request port. It then waits for the card side to return a byte count and up to sixteen response bytes. From that response it works out the completion outcome and stores the bytes in eight 16-bit response words.

The command word is split as follows:
- bits 5:0 hold the index
- bit 7 is the init flag
- bits 10:8 give the response type
- bit 11 is busy
- bits 13:12 give the command kind
- bit 15 gives the direction

The response type sets how many bytes must come back and which card-status error mask applies. A data-carrying command kind tells the neighbouring data path to empty its buffer and start a transfer. A status register records completion, the extra completion flag for the stop command, timeout and card error. It is cleared by write-one-to-clear or by disabling the controller.

All register writes arrive on one write port. A select value picks the target:
- 0 is the command word
- 1 is the low argument half
- 2 is the high argument half
- 3 is the control word, where bit 11 is the enable
- 4 is the status clear

Top module: `sdc_cmd_host`

## Requirements
- R1: An accepted command write raises `card_req` on the next cycle, with `card_index` equal to word bits 5:0 and `card_arg` equal to {high half, low half}. All three hold steady until a cycle with `card_ack` high, after which `card_req` is low.
- R2: Response types 1, 3 and 6 need 4 bytes and type 2 needs 16 bytes. If the returned count is smaller, status bit 7 (timeout) is set and bit 0 is not. Types 0, 4, 5 and 7 have no length check.
- R3: A response that is not a timeout sets status bit 0. For index 12 it also sets status bit 2.
- R4: Status bit 14 is updated on every response. For type 1 it is set when the big-endian word formed from bytes 0..3 has any bit of 0xFDF90000 set. For type 6 it is set when the word {byte 2, byte 3} has any bit of 0xE008 set. In every other case, timeouts included, it is cleared.
- R5: Every accepted command write clears all response words. On a non-timeout response of type 1, 2, 3 or 6, response word 7-k becomes {byte 2k, byte 2k+1}; word j sits at `rsp_flat[16j+:16]`. For any other outcome the words stay zero.
- R6: A command with the init flag set and index 0 sets status bit 0 on the write edge and issues no card request.
- R7: An issued command of kind 3 pulses `fifo_clear` for one cycle, sets `xfer_active` and latches bit 15 into `xfer_dir`. Any other issued kind clears `xfer_active`.
- R8: While the enable bit is clear, command writes are ignored: no request is made and the response words are unchanged.
- R9: Writing the control word with bit 11 clear zeroes the status register and pulses `fifo_clear`.
- R10: Writing the status-clear select clears exactly the status bits written as one.
- R11: A command write made while a request is outstanding is ignored.
- R12: Type 1 with the busy bit set behaves exactly like type 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Write target select |
| wr_data | input | 16 | Write data |
| card_req | output | 1 | Card request pending |
| card_index | output | 6 | Command index to the card |
| card_arg | output | 32 | Command argument to the card |
| card_ack | input | 1 | Card response valid |
| card_count | input | 5 | Number of response bytes returned (0..16) |
| card_bytes | input | 128 | Response bytes, byte i at [8i+:8] |
| enable | output | 1 | Controller enable |
| status | output | 16 | Status flags |
| rsp_flat | output | 128 | Eight response words, word j at [16j+:16] |
| xfer_active | output | 1 | Data transfer started |
| xfer_dir | output | 1 | Latched data direction |
| fifo_clear | output | 1 | One-cycle buffer flush pulse |

## Verification
The assertions check the following on every cycle:
- the request and its index and argument stay stable until acknowledged
- a timeout never coincides with a new completion
- the stop flag only rises together with completion
- disabling zeroes the status
- a flush pulse from a command comes with an active transfer
- response words are zero when a request starts
- ignored writes while disabled leave the outputs untouched

The bench sweeps every response type against short, exact and long byte counts, and walks each single bit of the card-status word for types 1 and 6. Only these scenarios can show the exact mask contents, the word ordering, and the interaction of clears, the init command and writes made during an outstanding request.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
    localparam int WORD_W      = 16;
    localparam int RSP_WORDS   = 8;
    localparam int RSP_W       = WORD_W * RSP_WORDS;
    localparam int RSP_BYTES   = RSP_W / 8;
    localparam int SHORT_BYTES = 4;
    localparam int CNT_W       = $clog2(RSP_BYTES + 1);
    localparam int IDX_W       = 6;
    localparam int ARG_W       = 2 * WORD_W;

    localparam int ST_DONE  = 0;
    localparam int ST_STOP  = 2;
    localparam int ST_TMO   = 7;
    localparam int ST_CERR  = 14;
    localparam int CTRL_EN_BIT = 11;
    localparam logic [IDX_W-1:0] STOP_IDX = 6'd12;

    localparam logic [2:0] RT_NONE = 3'd0;
    localparam logic [2:0] RT_R1   = 3'd1;
    localparam logic [2:0] RT_R2   = 3'd2;
    localparam logic [2:0] RT_R3   = 3'd3;
    localparam logic [2:0] RT_R6   = 3'd6;

    localparam logic [31:0] SHORT_ERR_MASK = 32'hFDF9_0000;
    localparam logic [15:0] RCA_ERR_MASK   = 16'hE008;

    typedef enum logic [2:0] {
        SEL_CMD      = 3'd0,
        SEL_ARG_LO   = 3'd1,
        SEL_ARG_HI   = 3'd2,
        SEL_CTRL     = 3'd3,
        SEL_STAT_CLR = 3'd4
    } reg_sel_e;

    typedef enum logic [1:0] {
        CK_BCAST    = 2'd0,
        CK_BCAST_RS = 2'd1,
        CK_ADDR     = 2'd2,
        CK_ADDR_DAT = 2'd3
    } cmd_kind_e;

    typedef struct packed {
        logic             dir;
        cmd_kind_e        kind;
        logic             busy;
        logic [2:0]       rtype;
        logic             init;
        logic [IDX_W-1:0] idx;
    } cmd_fields_t;

    function automatic logic [CNT_W-1:0] need_bytes(input logic [2:0] rt);
        case (rt)
            RT_R1, RT_R3, RT_R6: return CNT_W'(SHORT_BYTES);
            RT_R2:               return CNT_W'(RSP_BYTES);
            default:             return '0;
        endcase
    endfunction
endpackage

// File: rtl/sdc_cmd_decode.sv
module sdc_cmd_decode
    import sdc_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output cmd_fields_t       fields
);
    logic unused_bits;
    assign unused_bits = ^{word[14], word[6]};

    always_comb begin
        fields.idx   = word[5:0];
        fields.init  = word[7];
        fields.rtype = word[10:8];
        fields.busy  = word[11];
        fields.kind  = cmd_kind_e'(word[13:12]);
        fields.dir   = word[15];
    end
endmodule

// File: rtl/sdc_resp_eval.sv
module sdc_resp_eval
    import sdc_pkg::*;
(
    input  logic [2:0]       rtype,
    input  logic [CNT_W-1:0] count,
    input  logic [RSP_W-1:0] bytes,
    output logic             timeout,
    output logic             card_err,
    output logic             keep,
    output logic [RSP_W-1:0] words
);
    logic [CNT_W-1:0] need;
    logic [31:0]      short_word;
    logic [15:0]      rca_word;

    assign need       = need_bytes(rtype);
    assign timeout    = (need != '0) && (count < need);
    assign keep       = (need != '0) && !timeout;
    assign short_word = {bytes[7:0], bytes[15:8], bytes[23:16], bytes[31:24]};
    assign rca_word   = {bytes[23:16], bytes[31:24]};

    always_comb begin
        card_err = 1'b0;
        if (!timeout) begin
            if (rtype == RT_R1)
                card_err = |(short_word & SHORT_ERR_MASK);
            else if (rtype == RT_R6)
                card_err = |(rca_word & RCA_ERR_MASK);
        end
    end

    // word k of the byte stream (big-endian pair) lands in slot RSP_WORDS-1-k
    for (genvar k = 0; k < RSP_WORDS; k++) begin : g_pack
        logic [WORD_W-1:0] pair;
        assign pair = bytes[k*WORD_W +: WORD_W];
        assign words[(RSP_WORDS-1-k)*WORD_W +: WORD_W] = {pair[7:0], pair[15:8]};
    end
endmodule

// File: rtl/sdc_cmd_host.sv
module sdc_cmd_host
    import sdc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [2:0]       wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    output logic             card_req,
    output logic [IDX_W-1:0] card_index,
    output logic [ARG_W-1:0] card_arg,
    input  logic             card_ack,
    input  logic [CNT_W-1:0] card_count,
    input  logic [RSP_W-1:0] card_bytes,
    output logic             enable,
    output logic [WORD_W-1:0] status,
    output logic [RSP_W-1:0] rsp_flat,
    output logic             xfer_active,
    output logic             xfer_dir,
    output logic             fifo_clear
);
    cmd_fields_t       dec;
    reg_sel_e          sel;
    logic              enable_q, req_q, stop_q, xact_q, xdir_q, fclr_q;
    logic [2:0]        rtype_q;
    logic [IDX_W-1:0]  idx_q;
    logic [ARG_W-1:0]  arg_q, arg_out_q;
    logic [WORD_W-1:0] status_q, status_nxt;
    logic [RSP_W-1:0]  rsp_q, words;
    logic              tmo, cerr, keep;
    logic              cmd_take, init0, issue, ack_take, stat_clr, ctrl_wr, disable_wr;
    logic              unused_busy;

    sdc_cmd_decode u_dec (
        .word   (wr_data),
        .fields (dec)
    );

    sdc_resp_eval u_eval (
        .rtype    (rtype_q),
        .count    (card_count),
        .bytes    (card_bytes),
        .timeout  (tmo),
        .card_err (cerr),
        .keep     (keep),
        .words    (words)
    );

    // busy only promotes R1 to R1b, which needs no different handling here
    assign unused_busy = dec.busy;

    assign sel        = reg_sel_e'(wr_sel);
    assign cmd_take   = wr_en && (sel == SEL_CMD) && enable_q && !req_q;
    assign init0      = cmd_take && dec.init && (dec.idx == '0);
    assign issue      = cmd_take && !init0;
    assign ack_take   = req_q && card_ack;
    assign stat_clr   = wr_en && (sel == SEL_STAT_CLR);
    assign ctrl_wr    = wr_en && (sel == SEL_CTRL);
    assign disable_wr = ctrl_wr && !wr_data[CTRL_EN_BIT];

    always_comb begin
        status_nxt = status_q;
        if (stat_clr)
            status_nxt = status_nxt & ~wr_data;
        if (ack_take) begin
            status_nxt[ST_CERR] = cerr;
            if (tmo) begin
                status_nxt[ST_TMO] = 1'b1;
            end else begin
                status_nxt[ST_DONE] = 1'b1;
                if (stop_q)
                    status_nxt[ST_STOP] = 1'b1;
            end
        end
        if (init0)
            status_nxt[ST_DONE] = 1'b1;
        if (disable_wr)
            status_nxt = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            enable_q  <= 1'b0;
            req_q     <= 1'b0;
            stop_q    <= 1'b0;
            xact_q    <= 1'b0;
            xdir_q    <= 1'b0;
            fclr_q    <= 1'b0;
            rtype_q   <= RT_NONE;
            idx_q     <= '0;
            arg_q     <= '0;
            arg_out_q <= '0;
            status_q  <= '0;
            rsp_q     <= '0;
        end else begin
            fclr_q   <= disable_wr;
            status_q <= status_nxt;
            if (ctrl_wr)
                enable_q <= wr_data[CTRL_EN_BIT];
            if (wr_en && sel == SEL_ARG_LO)
                arg_q[WORD_W-1:0] <= wr_data;
            if (wr_en && sel == SEL_ARG_HI)
                arg_q[ARG_W-1:WORD_W] <= wr_data;
            if (cmd_take)
                rsp_q <= '0;
            if (issue) begin
                req_q     <= 1'b1;
                idx_q     <= dec.idx;
                rtype_q   <= dec.rtype;
                stop_q    <= (dec.idx == STOP_IDX);
                arg_out_q <= arg_q;
                if (dec.kind == CK_ADDR_DAT) begin
                    xact_q <= 1'b1;
                    xdir_q <= dec.dir;
                    fclr_q <= 1'b1;
                end else begin
                    xact_q <= 1'b0;
                end
            end
            if (ack_take) begin
                req_q <= 1'b0;
                if (keep)
                    rsp_q <= words;
            end
        end
    end

    assign card_req    = req_q;
    assign card_index  = idx_q;
    assign card_arg    = arg_out_q;
    assign enable      = enable_q;
    assign status      = status_q;
    assign rsp_flat    = rsp_q;
    assign xfer_active = xact_q;
    assign xfer_dir    = xdir_q;
    assign fifo_clear  = fclr_q;
endmodule

// File: rtl/sdc_cmd_chk.sv
module sdc_cmd_chk
    import sdc_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [2:0]       wr_sel,
    input logic             card_req,
    input logic [IDX_W-1:0] card_index,
    input logic [ARG_W-1:0] card_arg,
    input logic             card_ack,
    input logic             enable,
    input logic [WORD_W-1:0] status,
    input logic [RSP_W-1:0] rsp_flat,
    input logic             xfer_active,
    input logic             fifo_clear
);
    // R1 R11
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        card_req && !card_ack |=> card_req && $stable(card_index) && $stable(card_arg));

    // R2
    tmo_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(status[ST_TMO]) |-> $past(card_req && card_ack) && !$rose(status[ST_DONE]));

    // R3
    stop_done_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(status[ST_STOP]) |-> status[ST_DONE]);

    // R5
    rsp_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(card_req) |-> rsp_flat == '0);

    // R7
    flush_xfer_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_clear && enable |-> xfer_active);

    // R8
    off_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en && wr_sel == SEL_CMD && !enable && !card_req |=> !card_req && $stable(rsp_flat));

    // R9
    disable_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(enable) |-> status == '0 && fifo_clear);
endmodule

bind sdc_cmd_host sdc_cmd_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_sel      (wr_sel),
    .card_req    (card_req),
    .card_index  (card_index),
    .card_arg    (card_arg),
    .card_ack    (card_ack),
    .enable      (enable),
    .status      (status),
    .rsp_flat    (rsp_flat),
    .xfer_active (xfer_active),
    .fifo_clear  (fifo_clear)
);

// File: tb/sdc_cmd_host_tb.sv
module sdc_cmd_host_tb_top;
    import sdc_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [2:0]        wr_sel = 3'd0;
    logic [15:0]       wr_data = '0;
    logic              card_req;
    logic [5:0]        card_index;
    logic [31:0]       card_arg;
    logic              card_ack = 1'b0;
    logic [4:0]        card_count = '0;
    logic [127:0]      card_bytes = '0;
    logic              enable;
    logic [15:0]       status;
    logic [127:0]      rsp_flat;
    logic              xfer_active, xfer_dir, fifo_clear;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdc_cmd_host dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .card_req(card_req), .card_index(card_index), .card_arg(card_arg),
        .card_ack(card_ack), .card_count(card_count), .card_bytes(card_bytes),
        .enable(enable), .status(status), .rsp_flat(rsp_flat),
        .xfer_active(xfer_active), .xfer_dir(xfer_dir), .fifo_clear(fifo_clear)
    );

    task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [15:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [127:0] mk_bytes(input int seed);
        logic [127:0] b;
        for (int i = 0; i < 16; i++) b[8*i +: 8] = 8'((seed * 3 + i * 29 + 5) & 8'hFF);
        return b;
    endfunction

    function automatic int need_of(input int rt);
        if (rt == 1 || rt == 3 || rt == 6) return 4;
        if (rt == 2) return 16;
        return 0;
    endfunction

    function automatic logic [15:0] exp_status(input int rt, input int idx, input int cnt, input logic [127:0] b);
        logic [15:0] s;
        logic [31:0] w1;
        logic [15:0] w6;
        bit err;
        int need;
        need = need_of(rt);
        if (need != 0 && cnt < need) return 16'h0080;
        s = 16'h0001;
        if (idx == 12) s |= 16'h0004;
        w1 = {b[7:0], b[15:8], b[23:16], b[31:24]};
        w6 = {b[23:16], b[31:24]};
        err = (rt == 1) ? ((w1 & 32'hFDF90000) != 0) : (rt == 6) ? ((w6 & 16'hE008) != 0) : 1'b0;
        if (err) s |= 16'h4000;
        return s;
    endfunction

    function automatic logic [127:0] exp_rsp(input int rt, input int cnt, input logic [127:0] b);
        logic [127:0] r;
        int need;
        r = '0;
        need = need_of(rt);
        if (need != 0 && cnt >= need)
            for (int j = 0; j < 8; j++)
                r[16*j +: 16] = {b[8*(2*(7-j)) +: 8], b[8*(2*(7-j)+1) +: 8]};
        return r;
    endfunction

    // issue a command, check the request, answer it and check the outcome
    task automatic do_cmd(input logic [15:0] cw, input int cnt, input logic [127:0] b,
                          input logic [31:0] exp_arg, input string tag);
        int rt, idx;
        logic [15:0] es;
        logic [127:0] er;
        rt  = int'(cw[10:8]);
        idx = int'(cw[5:0]);
        wr(SEL_STAT_CLR, 16'hFFFF);
        wr(SEL_CMD, cw);
        check(card_req == 1'b1, {"R1 req ", tag}, 128'(card_req), 128'(1));
        check(card_index == cw[5:0], {"R1 index ", tag}, 128'(card_index), 128'(cw[5:0]));
        check(card_arg == exp_arg, {"R1 arg ", tag}, 128'(card_arg), 128'(exp_arg));
        check(rsp_flat == '0, {"R5 cleared ", tag}, rsp_flat, '0);
        if (cw[13:12] == 2'd3)
            check(xfer_active && fifo_clear && xfer_dir == cw[15], {"R7 data kind ", tag},
                  128'({xfer_active, fifo_clear, xfer_dir}), 128'({2'b11, cw[15]}));
        else
            check(!xfer_active, {"R7 other kind ", tag}, 128'(xfer_active), 128'(0));
        card_ack = 1'b1; card_count = 5'(cnt); card_bytes = b;
        @(negedge clk);
        card_ack = 1'b0;
        es = exp_status(rt, idx, cnt, b);
        er = exp_rsp(rt, cnt, b);
        check(!card_req, {"R1 released ", tag}, 128'(card_req), 128'(0));
        check(status == es, {"R2/R3/R4/R12 status ", tag}, 128'(status), 128'(es));
        check(rsp_flat == er, {"R5 words ", tag}, rsp_flat, er);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(status == '0 && !card_req && rsp_flat == '0 && !enable && !xfer_active,
              "reset state", 128'({status, card_req, enable, xfer_active}), '0);

        // R8: disabled command write does nothing
        wr(SEL_CMD, 16'h0105);
        check(!card_req, "R8 disabled no request", 128'(card_req), 128'(0));

        wr(SEL_CTRL, 16'h0800);
        wr(SEL_ARG_LO, 16'hBEEF);
        wr(SEL_ARG_HI, 16'h1234);

        // R6: init with index 0
        wr(SEL_STAT_CLR, 16'hFFFF);
        wr(SEL_CMD, 16'h0180);
        check(!card_req, "R6 no request", 128'(card_req), 128'(0));
        check(status == 16'h0001, "R6 status", 128'(status), 128'(16'h0001));

        // sweep response types x byte counts
        for (int rt = 0; rt < 8; rt++) begin
            for (int ci = 0; ci < 5; ci++) begin
                int cnt, idx;
                logic [15:0] cw;
                cnt = (ci == 0) ? 0 : (ci == 1) ? 3 : (ci == 2) ? 4 : (ci == 3) ? 15 : 16;
                idx = (ci == 2) ? 12 : (rt * 5 + ci + 1) % 64;
                cw = {ci[0], 1'b0, 2'(rt % 4), ci[1], 3'(rt), 2'b00, 6'(idx)};
                do_cmd(cw, cnt, mk_bytes(rt * 7 + ci), 32'h1234BEEF, "sweep");
            end
        end

        // R4: walk every card-status bit for type 1 and type 6
        for (int bt = 0; bt < 32; bt++) begin
            logic [31:0] w;
            logic [127:0] b;
            w = 32'h1 << bt;
            b = '0;
            b[31:0] = {w[7:0], w[15:8], w[23:16], w[31:24]};
            do_cmd(16'h0107, 4, b, 32'h1234BEEF, "R4 short mask walk");
        end
        for (int bt = 0; bt < 16; bt++) begin
            logic [15:0] w;
            logic [127:0] b;
            w = 16'h1 << bt;
            b = '0;
            b[31:16] = {w[7:0], w[15:8]};
            do_cmd(16'h0603, 4, b, 32'h1234BEEF, "R4 rca mask walk");
        end
        // R12: busy flag on type 1 changes nothing
        do_cmd(16'h0911, 4, 128'h0000_0080, 32'h1234BEEF, "R12 busy");

        // R11: second command during an outstanding request is ignored
        wr(SEL_STAT_CLR, 16'hFFFF);
        wr(SEL_CMD, 16'h0105);
        wr(SEL_CMD, 16'h0109);
        check(card_req && card_index == 6'd5, "R11 index kept", 128'(card_index), 128'(5));
        card_ack = 1'b1; card_count = 5'd4; card_bytes = '0;
        @(negedge clk);
        card_ack = 1'b0;
        check(status == 16'h0001, "R11 single completion", 128'(status), 128'(1));

        // R10: write-one-to-clear on a single bit
        do_cmd(16'h000C, 0, '0, 32'h1234BEEF, "R3 stop");
        wr(SEL_STAT_CLR, 16'h0001);
        check(status == 16'h0004, "R10 partial clear", 128'(status), 128'(16'h0004));

        // fill response words, then disable
        do_cmd(16'h0202, 16, mk_bytes(99), 32'h1234BEEF, "long");
        wr(SEL_CTRL, 16'h0000);
        check(status == '0 && fifo_clear, "R9 disable clears", 128'({status, fifo_clear}), 128'(1));
        wr(SEL_CMD, 16'h0202);
        check(!card_req, "R8 ignored request", 128'(card_req), 128'(0));
        check(rsp_flat == exp_rsp(2, 16, mk_bytes(99)), "R8 words kept", rsp_flat, exp_rsp(2, 16, mk_bytes(99)));

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule